// File: doc/BRIEF.md
# Transmitter Power-Up Step Sequencer

This block brings a display transmitter macro out of power-down in hardware. It drives seven active-high power-down controls and releases them in a fixed order. Between releases it waits for intervals of different lengths, counted in pulses of a one-microsecond tick input. A single start pulse runs the whole sequence. A one-cycle done pulse and a sticky power-up flag report that it has finished. Once the flag is set, further start pulses do nothing until an explicit power-down request clears it.

Before the first release, the block loads the link-speed field. In LVDS mode it loads the LVDS code; otherwise it loads the lowest DP rate code. The second step takes the I/O pads out of deep power-down, which needs a handshake with the pad controller. The block enables status sampling, loads the timing-select value and drops the deep-power-down control. It then reads the controller's busy status once every poll interval. It stops polling when the busy bit reads clear or when the time budget runs out. If the budget runs out, it raises a sticky timeout flag and carries on with the sequence. Sampling is switched off again when polling stops.

Top module: `txpwr_seq`

## Requirements
- R1: After reset all seven controls in `pd_ctl` are asserted, and `power_is_up`, `done`, `dpd_sample_en` and `dpd_timeout` are 0. The bit order of `pd_ctl` is: 0 port, 1 PLL, 2 bandgap, 3 VCO, 4 PLL capacitor, 5 I/O deep power-down, 6 pad calibration.
- R2: The cycle after a start pulse is accepted, `pd_ctl` is 7'h7F. In the same cycle `link_speed` holds 8'h07 if `lvds_mode` was 1, or 8'h06 otherwise. An accepted start also clears `dpd_timeout`.
- R3: One cycle later, `pd_ctl[5]` drops to 0, `dpd_sample_en` rises to 1 and `dpd_timing` becomes 10.
- R4: While sampling, `dpd_busy` is read on every 20th tick. The first read that finds it 0 ends polling, and `dpd_sample_en` returns to 0 in the next cycle.
- R5: If `dpd_busy` is still 1 at the read that completes 10000 ticks (the 500th read), polling ends, `dpd_timeout` goes to 1 and the sequence continues. The flag stays set until the next accepted start.
- R6: When 15 ticks have passed after polling ends, `pd_ctl[2]` drops. No other control changes at that point.
- R7: When a further 25 ticks have passed, `pd_ctl[1]`, `pd_ctl[3]` and `pd_ctl[4]` drop together.
- R8: When a further 225 ticks have passed, `pd_ctl[0]` drops, `done` pulses for exactly one cycle, and `power_is_up` becomes 1 in that same cycle.
- R9: `pd_ctl[6]` (pad calibration) stays asserted at all times.
- R10: A start pulse while `power_is_up` is 1 changes no output and produces no `done` pulse.
- R11: A `power_down` pulse, in any state, causes the following: the next cycle has `pd_ctl` at 7'h7F and `power_is_up` at 0, any running sequence is abandoned, and no `done` pulse follows.
- R12: A start pulse while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Request to run the power-up sequence |
| power_down | input | 1 | Clear the power-up flag and re-assert all controls |
| lvds_mode | input | 1 | Selects the LVDS link-speed code at start |
| dpd_busy | input | 1 | Pad controller status: still in deep power-down |
| pd_ctl | output | 7 | Active-high power-down controls (bit order in R1) |
| link_speed | output | 8 | Link-speed field loaded at start |
| dpd_sample_en | output | 1 | Status sampling enable during release |
| dpd_timing | output | 8 | Deep-power-down timing select |
| dpd_timeout | output | 1 | Sticky: release status never cleared in budget |
| done | output | 1 | One-cycle pulse when the sequence completes |
| power_is_up | output | 1 | Sticky power-up flag |

## Verification
Every output is registered, so a wrong internal state shows at the ports by the next cycle. A step counter that is off by one would move a control edge by one tick or release a control out of order. A sampling counter that is off by one would move the fall of `dpd_sample_en`, or would cause the timeout to be missed or to fire when it should not. A behavioural model in the bench counts ticks and polls separately and is compared with every output on every clock, so a mismatch is caught in the cycle it first appears. Test runs cover a clear first poll, a late clear, a full timeout, starts that should be ignored, and power-down both during a sequence and after completion.

// File: rtl/txpwr_pkg.sv
package txpwr_pkg;

    localparam int PD_N   = 7;
    localparam int STEP_W = 3;

    localparam int PD_PORT = 0;
    localparam int PD_PLL  = 1;
    localparam int PD_BG   = 2;
    localparam int PD_VCO  = 3;
    localparam int PD_CAP  = 4;
    localparam int PD_DPD  = 5;
    localparam int PD_CAL  = 6;

    localparam logic [STEP_W-1:0] STEP_ALL = 3'd1;
    localparam logic [STEP_W-1:0] STEP_DPD = 3'd2;
    localparam logic [STEP_W-1:0] STEP_BG  = 3'd3;
    localparam logic [STEP_W-1:0] STEP_PLL = 3'd4;
    localparam logic [STEP_W-1:0] STEP_END = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_POLL,
        ST_SETTLE,
        ST_BG,
        ST_PLL
    } seq_st_e;

    // Step at which a control is released; 7 means never.
    function automatic logic [STEP_W-1:0] release_step(input int bit_idx);
        case (bit_idx)
            PD_PORT:                 release_step = STEP_END;
            PD_PLL, PD_VCO, PD_CAP:  release_step = STEP_PLL;
            PD_BG:                   release_step = STEP_BG;
            PD_DPD:                  release_step = STEP_DPD;
            default:                 release_step = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/txpwr_us_timer.sv
module txpwr_us_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          us_tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = us_tick && (cnt_q == limit - 1'b1);
        cnt_d  = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (us_tick) begin
            cnt_d = expire ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/txpwr_poll_budget.sv
module txpwr_poll_budget #(
    parameter int MAX_POLLS = 500,
    parameter int PW        = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic poll,
    output logic last
);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        last  = (cnt_q == PW'(MAX_POLLS - 1));
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (poll && !last) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/txpwr_step_mask.sv
module txpwr_step_mask
    import txpwr_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    output logic [PD_N-1:0]   pd
);

    for (genvar i = 0; i < PD_N; i++) begin : g_bit
        localparam logic [STEP_W-1:0] REL = release_step(i);
        assign pd[i] = (step < REL);
    end

endmodule

// File: rtl/txpwr_seq.sv
module txpwr_seq
    import txpwr_pkg::*;
#(
    parameter int POLL_US   = 20,
    parameter int BUDGET_US = 10000,
    parameter int SETTLE_US = 15,
    parameter int BG_US     = 25,
    parameter int PLL_US    = 225,
    parameter int SPD_W     = 8,
    parameter int SPD_LVDS  = 7,
    parameter int SPD_LOW   = 6,
    parameter int TSW       = 8,
    parameter int DPD_TSEL  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             start,
    input  logic             power_down,
    input  logic             lvds_mode,
    input  logic             dpd_busy,
    output logic [6:0]       pd_ctl,
    output logic [SPD_W-1:0] link_speed,
    output logic             dpd_sample_en,
    output logic [TSW-1:0]   dpd_timing,
    output logic             dpd_timeout,
    output logic             done,
    output logic             power_is_up
);

    localparam int MAX_POLLS = (BUDGET_US + POLL_US - 1) / POLL_US;
    localparam int PW        = $clog2(MAX_POLLS + 1);
    localparam int TMAX_A    = (POLL_US > SETTLE_US) ? POLL_US : SETTLE_US;
    localparam int TMAX_B    = (BG_US > PLL_US) ? BG_US : PLL_US;
    localparam int TMAX      = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TW        = $clog2(TMAX + 1);

    typedef struct packed {
        seq_st_e           st;
        logic [STEP_W-1:0] step;
        logic [SPD_W-1:0]  speed;
        logic              samp;
        logic [TSW-1:0]    tsel;
        logic              err;
        logic              up;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic          tmr_clr, tmr_exp;
    logic [TW-1:0] tmr_lim;
    logic          poll_clr, poll_stb, poll_last;
    logic [PD_N-1:0] pd_mask;

    txpwr_us_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .us_tick(us_tick),
        .limit  (tmr_lim),
        .expire (tmr_exp)
    );

    txpwr_poll_budget #(.MAX_POLLS(MAX_POLLS), .PW(PW)) u_budget (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (poll_clr),
        .poll (poll_stb),
        .last (poll_last)
    );

    txpwr_step_mask u_mask (
        .step(r_q.step),
        .pd  (pd_mask)
    );

    // Wait length for the current state.
    always_comb begin
        case (r_q.st)
            ST_POLL:   tmr_lim = TW'(POLL_US);
            ST_SETTLE: tmr_lim = TW'(SETTLE_US);
            ST_BG:     tmr_lim = TW'(BG_US);
            ST_PLL:    tmr_lim = TW'(PLL_US);
            default:   tmr_lim = TW'(TMAX);
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_clr  = 1'b0;
        poll_clr = 1'b0;
        poll_stb = 1'b0;
        if (power_down) begin
            r_d.st   = ST_IDLE;
            r_d.step = STEP_ALL;
            r_d.up   = 1'b0;
            r_d.samp = 1'b0;
            tmr_clr  = 1'b1;
            poll_clr = 1'b1;
        end else begin
            case (r_q.st)
                ST_IDLE: begin
                    tmr_clr  = 1'b1;
                    poll_clr = 1'b1;
                    if (start && !r_q.up) begin
                        r_d.st    = ST_ARM;
                        r_d.step  = STEP_ALL;
                        r_d.speed = lvds_mode ? SPD_W'(SPD_LVDS) : SPD_W'(SPD_LOW);
                        r_d.err   = 1'b0;
                    end
                end
                ST_ARM: begin
                    tmr_clr  = 1'b1;
                    poll_clr = 1'b1;
                    r_d.st   = ST_POLL;
                    r_d.step = STEP_DPD;
                    r_d.samp = 1'b1;
                    r_d.tsel = TSW'(DPD_TSEL);
                end
                ST_POLL: begin
                    if (tmr_exp) begin
                        poll_stb = 1'b1;
                        if (!dpd_busy || poll_last) begin
                            r_d.err  = r_q.err | dpd_busy;
                            r_d.samp = 1'b0;
                            r_d.st   = ST_SETTLE;
                            tmr_clr  = 1'b1;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (tmr_exp) begin
                        r_d.step = STEP_BG;
                        r_d.st   = ST_BG;
                        tmr_clr  = 1'b1;
                    end
                end
                ST_BG: begin
                    if (tmr_exp) begin
                        r_d.step = STEP_PLL;
                        r_d.st   = ST_PLL;
                        tmr_clr  = 1'b1;
                    end
                end
                ST_PLL: begin
                    if (tmr_exp) begin
                        r_d.step = STEP_END;
                        r_d.st   = ST_IDLE;
                        r_d.up   = 1'b1;
                        r_d.done = 1'b1;
                        tmr_clr  = 1'b1;
                    end
                end
                default: begin
                    r_d.st   = ST_IDLE;
                    r_d.step = STEP_ALL;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.step  <= STEP_ALL;
            r_q.speed <= '0;
            r_q.samp  <= 1'b0;
            r_q.tsel  <= '0;
            r_q.err   <= 1'b0;
            r_q.up    <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pd_ctl        = pd_mask;
    assign link_speed    = r_q.speed;
    assign dpd_sample_en = r_q.samp;
    assign dpd_timing    = r_q.tsel;
    assign dpd_timeout   = r_q.err;
    assign done          = r_q.done;
    assign power_is_up   = r_q.up;

endmodule

// File: rtl/txpwr_seq_chk.sv
module txpwr_seq_chk #(
    parameter int TSW      = 8,
    parameter int DPD_TSEL = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           power_down,
    input logic [6:0]     pd_ctl,
    input logic           power_is_up,
    input logic           done,
    input logic           dpd_sample_en,
    input logic [TSW-1:0] dpd_timing
);

    p_cal_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pd_ctl[6]);

    p_sample_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dpd_sample_en) |-> (!pd_ctl[5] && dpd_timing == TSW'(DPD_TSEL)));

    p_bg_after_dpd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_ctl[2]) |-> (!pd_ctl[5] && !dpd_sample_en && pd_ctl[1]));

    p_pll_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_ctl[1]) |-> (!pd_ctl[3] && !pd_ctl[4] && !pd_ctl[2] && pd_ctl[0]));

    p_done_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (power_is_up && pd_ctl[5:0] == 6'd0));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ignore_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (power_is_up && start && !power_down) |=> ($stable(pd_ctl) && !done && power_is_up));

    p_power_down_r11: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> (pd_ctl == 7'h7F && !power_is_up && !done));

endmodule

bind txpwr_seq txpwr_seq_chk #(.TSW(TSW), .DPD_TSEL(DPD_TSEL)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .power_down   (power_down),
    .pd_ctl       (pd_ctl),
    .power_is_up  (power_is_up),
    .done         (done),
    .dpd_sample_en(dpd_sample_en),
    .dpd_timing   (dpd_timing)
);

// File: tb/tb_txpwr_seq.sv
module tb_txpwr_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       start = 1'b0;
    logic       power_down = 1'b0;
    logic       lvds_mode = 1'b0;
    logic       dpd_busy = 1'b0;
    logic [6:0] pd_ctl;
    logic [7:0] link_speed;
    logic       dpd_sample_en;
    logic [7:0] dpd_timing;
    logic       dpd_timeout;
    logic       done;
    logic       power_is_up;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit cmp_en = 1'b0;
    int tick_ph = 0;

    // Behavioural reference state
    int         m_ph = 0;
    int         m_cnt = 0;
    int         m_polls = 0;
    logic [6:0] m_pd = 7'h7F;
    int         m_speed = 0;
    int         m_samp = 0;
    int         m_tsel = 0;
    int         m_err = 0;
    int         m_up = 0;
    int         m_done = 0;

    always #2 clk = ~clk;

    txpwr_seq dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start),
        .power_down(power_down), .lvds_mode(lvds_mode), .dpd_busy(dpd_busy),
        .pd_ctl(pd_ctl), .link_speed(link_speed), .dpd_sample_en(dpd_sample_en),
        .dpd_timing(dpd_timing), .dpd_timeout(dpd_timeout), .done(done),
        .power_is_up(power_is_up)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Tick every second cycle
    always @(negedge clk) begin
        tick_ph = (tick_ph + 1) % 2;
        us_tick = (tick_ph == 0);
    end

    // Reference model
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_polls = 0; m_pd = 7'h7F; m_speed = 0;
            m_samp = 0; m_tsel = 0; m_err = 0; m_up = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (power_down) begin
                m_ph = 0; m_pd = 7'h7F; m_up = 0; m_samp = 0;
            end else begin
                case (m_ph)
                    0: if (start && m_up == 0) begin
                        m_ph = 1; m_pd = 7'h7F; m_err = 0;
                        m_speed = lvds_mode ? 7 : 6;
                    end
                    1: begin
                        m_ph = 2; m_pd[5] = 1'b0; m_samp = 1; m_tsel = 10;
                        m_cnt = 0; m_polls = 0;
                    end
                    2: if (us_tick) begin
                        m_cnt++;
                        if (m_cnt == 20) begin
                            m_cnt = 0;
                            m_polls++;
                            if (!dpd_busy || m_polls * 20 >= 10000) begin
                                if (dpd_busy) m_err = 1;
                                m_samp = 0; m_ph = 3;
                            end
                        end
                    end
                    3: if (us_tick) begin
                        m_cnt++;
                        if (m_cnt == 15) begin m_cnt = 0; m_pd[2] = 1'b0; m_ph = 4; end
                    end
                    4: if (us_tick) begin
                        m_cnt++;
                        if (m_cnt == 25) begin
                            m_cnt = 0; m_pd[1] = 1'b0; m_pd[3] = 1'b0; m_pd[4] = 1'b0; m_ph = 5;
                        end
                    end
                    default: if (us_tick) begin
                        m_cnt++;
                        if (m_cnt == 225) begin
                            m_cnt = 0; m_pd[0] = 1'b0; m_up = 1; m_done = 1; m_ph = 0;
                        end
                    end
                endcase
            end
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R8 pd_ctl[0] vs model", int'(pd_ctl[0]), int'(m_pd[0]));
            chk("R7 pd_ctl[1] vs model", int'(pd_ctl[1]), int'(m_pd[1]));
            chk("R6 pd_ctl[2] vs model", int'(pd_ctl[2]), int'(m_pd[2]));
            chk("R7 pd_ctl[3] vs model", int'(pd_ctl[3]), int'(m_pd[3]));
            chk("R7 pd_ctl[4] vs model", int'(pd_ctl[4]), int'(m_pd[4]));
            chk("R3 pd_ctl[5] vs model", int'(pd_ctl[5]), int'(m_pd[5]));
            chk("R9 pd_ctl[6] vs model", int'(pd_ctl[6]), int'(m_pd[6]));
            chk("R2 link_speed vs model", int'(link_speed), m_speed);
            chk("R4 dpd_sample_en vs model", int'(dpd_sample_en), m_samp);
            chk("R3 dpd_timing vs model", int'(dpd_timing), m_tsel);
            chk("R5 dpd_timeout vs model", int'(dpd_timeout), m_err);
            chk("R8 done vs model", int'(done), m_done);
            chk("R8 power_is_up vs model", int'(power_is_up), m_up);
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic pulse_pd();
        @(negedge clk) power_down = 1'b1;
        @(negedge clk) power_down = 1'b0;
    endtask

    task automatic wait_done(input int max, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    task automatic wait_samp_low(input int max);
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (!dpd_sample_en) break;
        end
    endtask

    initial begin
        bit seen;
        int dones;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pd_ctl after reset", int'(pd_ctl), 'h7F);
        chk("R1 power_is_up after reset", int'(power_is_up), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 sample/timeout after reset", int'({dpd_sample_en, dpd_timeout}), 0);

        // Run 1: DP mode, status clear at first poll
        lvds_mode = 1'b0; dpd_busy = 1'b0;
        pulse_start();
        chk("R2 all asserted at step 1", int'(pd_ctl), 'h7F);
        chk("R2 low-rate speed code", int'(link_speed), 6);
        @(negedge clk);
        chk("R3 DPD released", int'(pd_ctl), 'h5F);
        chk("R3 sampling enabled", int'(dpd_sample_en), 1);
        chk("R3 timing select", int'(dpd_timing), 10);
        wait_samp_low(200);
        chk("R4 sampling off after clear poll", int'(dpd_sample_en), 0);
        chk("R6 bandgap held at poll exit", int'(pd_ctl[2]), 1);
        pulse_start();   // R12: ignored while running
        chk("R12 start ignored mid-sequence", int'(pd_ctl), 'h5F);
        wait_done(2000, seen);
        chk("R8 done seen", int'(seen), 1);
        chk("R8 power up flag", int'(power_is_up), 1);
        chk("R9 only calibration held", int'(pd_ctl), 'h40);

        // R10 start while up
        pulse_start();
        chk("R10 outputs unchanged", int'(pd_ctl), 'h40);
        chk("R10 no done", int'(done), 0);
        @(negedge clk);
        chk("R10 flag kept", int'(power_is_up), 1);

        // R11 power-down after completion
        pulse_pd();
        chk("R11 controls re-asserted", int'(pd_ctl), 'h7F);
        chk("R11 flag cleared", int'(power_is_up), 0);

        // Run 2: LVDS mode, status clears late
        lvds_mode = 1'b1; dpd_busy = 1'b1;
        pulse_start();
        chk("R2 LVDS speed code", int'(link_speed), 7);
        repeat (100) @(negedge clk);
        chk("R4 sampling held while busy", int'(dpd_sample_en), 1);
        dpd_busy = 1'b0;
        wait_samp_low(200);
        chk("R4 exit on clear status", int'(dpd_sample_en), 0);
        chk("R5 no timeout on late clear", int'(dpd_timeout), 0);
        wait_done(2000, seen);
        chk("R8 done after late clear", int'(seen), 1);
        pulse_pd();

        // Run 3: status never clears -> timeout
        lvds_mode = 1'b0; dpd_busy = 1'b1;
        pulse_start();
        wait_samp_low(25000);
        chk("R5 sampling ends at budget", int'(dpd_sample_en), 0);
        @(negedge clk);
        chk("R5 timeout flag raised", int'(dpd_timeout), 1);
        wait_done(2000, seen);
        chk("R5 sequence continues to done", int'(seen), 1);
        chk("R5 timeout flag sticky", int'(dpd_timeout), 1);
        pulse_pd();

        // Run 4: abort during PLL wait
        dpd_busy = 1'b0;
        pulse_start();
        chk("R5 timeout cleared by start", int'(dpd_timeout), 0);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!pd_ctl[1]) break;
        end
        chk("R7 PLL group released", int'(pd_ctl), 'h41);
        pulse_pd();
        chk("R11 abort re-asserts all", int'(pd_ctl), 'h7F);
        chk("R11 flag low after abort", int'(power_is_up), 0);
        dones = 0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk("R11 no done after abort", dones, 0);

        // Run 5: fresh full run after abort
        pulse_start();
        wait_done(2000, seen);
        chk("R8 done after restart", int'(seen), 1);
        @(negedge clk);
        chk("R8 done is one cycle", int'(done), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule